// File: doc/BRIEF.md
# USB Host Port Status and Control Register

This block is the status and control register of one downstream USB 2.0 host port. It also holds the port's state machine. Software reaches it over a plain 32-bit register bus, with address, write enable, write data and a combinational read-data path. It sees the raw D+/D- line levels, a connect-detect input and the host controller's Run/Stop bit. From these it drives the bus-reset signalling, the suspend control and a forced high-speed enable toward the transceiver logic. It also produces a start-of-frame permission and a connect-change interrupt request.

The register sits in its own power domain. Only the asynchronous power-on reset or a synchronous host-controller reset pulse clears it. Software times the bus reset itself: it writes the reset bit to 1 to start the signalling and writes it to 0 to end it. The register accepts a reset start only while Run/Stop is 0.

The state machine has five states:
- DISC: no device.
- CONN: device present, port disabled.
- EN: port enabled.
- RST: bus reset in progress.
- SUSP: port suspended.

Its transitions are:
- attach: DISC to CONN, when connect is 1.
- detach: any state to DISC, when connect is 0. This has the highest priority.
- reset_start: CONN, EN or SUSP to RST, on a write with bit 8 set while Run/Stop is 0.
- reset_end: RST to EN, on a write with bit 8 clear.
- force_enable: CONN to EN, while the test-force bit is 1.
- suspend: EN to SUSP, on a write with bit 7 set.
- resume: SUSP to EN, on a write with bit 7 clear.

Top module: `usbh_portsc`

## Requirements
- R1: The register responds only at byte address 0x30. At any other address, reads return 0 and writes change nothing. Bits 31:17, 15:12, 9 and 6:3 always read as 0.
- R2: After power-on reset (por_n low) or a one-cycle host-controller reset pulse, the register reads 0. The state is DISC and every drive output is 0.
- R3: Bits 11:10 show the line input delayed by two clock edges, using the encoding 00=SE0, 10=J, 01=K, 11=undefined.
- R4: With connect at 1, DISC moves to CONN on the next edge. With connect at 0, every state returns to DISC on the next edge, which clears enable, suspend and reset together. Bit 0 reads 1 in every state other than DISC, and bit 2 reads 1 in EN and SUSP.
- R5: Bit 1, the connect-change flag, is set on the edge after the connect input differs from its previous registered value. It stays set until software writes bit 1 as 1. It is driven on csc_irq.
- R6: In CONN, EN or SUSP, a write with bit 8 = 1 while Run/Stop = 0 enters RST. Bit 8 and drv_reset read 1 while in RST. A write with bit 8 = 0 ends RST in EN.
- R7: A write with bit 8 = 1 while Run/Stop = 1 leaves the state unchanged and pulses prot_err high for exactly the following cycle.
- R8: A write with bit 7 = 1 moves EN to SUSP. In SUSP, bit 7 and drv_suspend read 1. A write with bit 7 = 0 (and bit 8 = 0) returns SUSP to EN. A write with bit 7 = 1 in DISC, CONN or RST does not enter SUSP.
- R9: Bit 16 is a read/write test-force bit that drives drv_force_hs. While it is 1, CONN moves to EN on the next edge.
- R10: sof_enable is 1 exactly when the state is EN and Run/Stop is 1.
- R11: A write with bit 8 = 1 in DISC does not start bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| hc_reset | input | 1 | Synchronous host-controller reset pulse |
| addr | input | 8 | Register byte address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data (combinational) |
| line_raw | input | 2 | Unsynchronized D+/D- line levels |
| connect | input | 1 | Device-present indication |
| run_stop | input | 1 | Host controller Run/Stop bit |
| drv_reset | output | 1 | Drive bus reset signalling |
| drv_suspend | output | 1 | Hold port in suspend |
| drv_force_hs | output | 1 | Force high-speed enable |
| port_enabled | output | 1 | Port enabled (EN or SUSP) |
| sof_enable | output | 1 | Start-of-frame output allowed |
| csc_irq | output | 1 | Connect-change interrupt request |
| prot_err | output | 1 | Protocol-error pulse |

## Verification
The assertions assume the following about the inputs:
- connect and run_stop are already synchronous to clk.
- hc_reset is a clean synchronous pulse.
- Writes last one cycle.

The stimulus changes every input on the falling edge and holds each write for exactly one rising edge, so each write is seen once. Before checking the disconnect, suspend and reset guards, the bench walks the port through each state, so every guarded write lands in a known state.

// File: rtl/usbh_portsc_pkg.sv
package usbh_portsc_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int LINE_W   = 2;

    localparam int B_CONN   = 0;
    localparam int B_CSC    = 1;
    localparam int B_EN     = 2;
    localparam int B_SUSP   = 7;
    localparam int B_RST    = 8;
    localparam int B_LINE   = 10;
    localparam int B_FORCE  = 16;

    typedef enum logic [2:0] {
        PS_DISC = 3'd0,
        PS_CONN = 3'd1,
        PS_EN   = 3'd2,
        PS_RST  = 3'd3,
        PS_SUSP = 3'd4
    } port_state_e;
endpackage

// File: rtl/usbh_line_sync.sv
module usbh_line_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];
    logic [1:0]   age;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            stage[0] <= '0;
        end else begin
            stage[0] <= d;
        end
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) begin
                    stage[i] <= '0;
                end else begin
                    stage[i] <= stage[i-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            age <= 2'd0;
        end else if (age != 2'd2) begin
            age <= age + 2'd1;
        end
    end

    // R3
    sync_lat_chk: assert property (@(posedge clk) disable iff (!por_n)
        (age == 2'd2 && STAGES == 2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/usbh_port_fsm.sv
module usbh_port_fsm
    import usbh_portsc_pkg::*;
(
    input  logic        clk,
    input  logic        por_n,
    input  logic        hc_reset,
    input  logic        connect,
    input  logic        run_stop,
    input  logic        wr_hit,
    input  logic        wr_rst,
    input  logic        wr_susp,
    input  logic        force_q,
    output port_state_e state,
    output logic        prot_err
);
    port_state_e nxt;
    logic        rst_req_ok;
    logic        rst_req_bad;

    assign rst_req_ok  = wr_hit && wr_rst && !run_stop;
    assign rst_req_bad = wr_hit && wr_rst && run_stop;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state <= PS_DISC;
        end else if (hc_reset) begin
            state <= PS_DISC;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        if (!connect) begin
            nxt = PS_DISC;
        end else begin
            unique case (state)
                PS_DISC: nxt = PS_CONN;
                PS_CONN: begin
                    if (rst_req_ok) nxt = PS_RST;
                    else if (force_q) nxt = PS_EN;
                end
                PS_EN: begin
                    if (rst_req_ok) nxt = PS_RST;
                    else if (wr_hit && !wr_rst && wr_susp) nxt = PS_SUSP;
                end
                PS_SUSP: begin
                    if (rst_req_ok) nxt = PS_RST;
                    else if (wr_hit && !wr_rst && !wr_susp) nxt = PS_EN;
                end
                PS_RST: begin
                    if (wr_hit && !wr_rst) nxt = PS_EN;
                end
                default: nxt = PS_DISC;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            prot_err <= 1'b0;
        end else if (hc_reset) begin
            prot_err <= 1'b0;
        end else begin
            prot_err <= rst_req_bad;
        end
    end

    // R4
    detach_chk: assert property (@(posedge clk) disable iff (!por_n || hc_reset)
        !connect |=> (state == PS_DISC));
    // R7
    rs_guard_chk: assert property (@(posedge clk) disable iff (!por_n || hc_reset)
        (rst_req_bad && state != PS_RST) |=> (state != PS_RST));
    // R7
    err_pulse_chk: assert property (@(posedge clk) disable iff (!por_n || hc_reset)
        rst_req_bad |=> prot_err);
    // R8
    susp_guard_chk: assert property (@(posedge clk) disable iff (!por_n || hc_reset)
        (state != PS_EN && state != PS_SUSP) |=> (state != PS_SUSP));
    // R11
    disc_rst_chk: assert property (@(posedge clk) disable iff (!por_n || hc_reset)
        (state == PS_DISC) |=> (state != PS_RST));
endmodule

// File: rtl/usbh_portsc.sv
module usbh_portsc
    import usbh_portsc_pkg::*;
#(
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h30
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              hc_reset,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [LINE_W-1:0] line_raw,
    input  logic              connect,
    input  logic              run_stop,
    output logic              drv_reset,
    output logic              drv_suspend,
    output logic              drv_force_hs,
    output logic              port_enabled,
    output logic              sof_enable,
    output logic              csc_irq,
    output logic              prot_err
);
    logic              hit;
    logic              wr_hit;
    logic              conn_q;
    logic              csc_q;
    logic              force_q;
    logic [LINE_W-1:0] line_s;
    port_state_e       state;
    logic [DATA_W-1:0] reg_view;

    assign hit    = (addr == REG_OFFSET);
    assign wr_hit = wr_en && hit;

    usbh_line_sync #(.W(LINE_W), .STAGES(2)) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .d     (line_raw),
        .q     (line_s)
    );

    usbh_port_fsm u_fsm (
        .clk      (clk),
        .por_n    (por_n),
        .hc_reset (hc_reset),
        .connect  (connect),
        .run_stop (run_stop),
        .wr_hit   (wr_hit),
        .wr_rst   (wdata[B_RST]),
        .wr_susp  (wdata[B_SUSP]),
        .force_q  (force_q),
        .state    (state),
        .prot_err (prot_err)
    );

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            conn_q  <= 1'b0;
            csc_q   <= 1'b0;
            force_q <= 1'b0;
        end else if (hc_reset) begin
            conn_q  <= 1'b0;
            csc_q   <= 1'b0;
            force_q <= 1'b0;
        end else begin
            conn_q <= connect;
            if (connect != conn_q) begin
                csc_q <= 1'b1;
            end else if (wr_hit && wdata[B_CSC]) begin
                csc_q <= 1'b0;
            end
            if (wr_hit) begin
                force_q <= wdata[B_FORCE];
            end
        end
    end

    always_comb begin
        reg_view                         = '0;
        reg_view[B_CONN]                 = (state != PS_DISC);
        reg_view[B_CSC]                  = csc_q;
        reg_view[B_EN]                   = (state == PS_EN) || (state == PS_SUSP);
        reg_view[B_SUSP]                 = (state == PS_SUSP);
        reg_view[B_RST]                  = (state == PS_RST);
        reg_view[B_LINE +: LINE_W]       = line_s;
        reg_view[B_FORCE]                = force_q;
    end

    assign rdata        = hit ? reg_view : '0;
    assign drv_reset    = (state == PS_RST);
    assign drv_suspend  = (state == PS_SUSP);
    assign drv_force_hs = force_q;
    assign port_enabled = (state == PS_EN) || (state == PS_SUSP);
    assign sof_enable   = (state == PS_EN) && run_stop;
    assign csc_irq      = csc_q;

    // R5
    csc_set_chk: assert property (@(posedge clk) disable iff (!por_n || hc_reset)
        (connect != conn_q) |=> csc_irq);
    // R5
    csc_clr_chk: assert property (@(posedge clk) disable iff (!por_n || hc_reset)
        (wr_hit && wdata[B_CSC] && connect == conn_q) |=> !csc_irq);
    // R9
    force_chk: assert property (@(posedge clk) disable iff (!por_n || hc_reset)
        wr_hit |=> (drv_force_hs == $past(wdata[B_FORCE])));
endmodule

// File: tb/sim_usbh_portsc.sv
module sim_usbh_portsc;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        hc_reset = 1'b0;
    logic [7:0]  addr = 8'h30;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  line_raw = 2'b00;
    logic        connect = 1'b0;
    logic        run_stop = 1'b0;
    logic        drv_reset, drv_suspend, drv_force_hs, port_enabled;
    logic        sof_enable, csc_irq, prot_err;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    usbh_portsc u0 (
        .clk(clk), .por_n(por_n), .hc_reset(hc_reset), .addr(addr),
        .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .line_raw(line_raw),
        .connect(connect), .run_stop(run_stop), .drv_reset(drv_reset),
        .drv_suspend(drv_suspend), .drv_force_hs(drv_force_hs),
        .port_enabled(port_enabled), .sof_enable(sof_enable),
        .csc_irq(csc_irq), .prot_err(prot_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one rising edge, back at falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wr_en = 1'b1; wdata = d;
        step();
        wr_en = 1'b0; wdata = '0; addr = 8'h30;
    endtask

    function automatic logic [31:0] outs();
        return {25'd0, drv_reset, drv_suspend, drv_force_hs, port_enabled,
                sof_enable, csc_irq, prot_err};
    endfunction

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [1:0] prev;
        @(negedge clk);
        @(negedge clk);
        por_n = 1'b1;
        step();
        // R2 power-on state
        chk("R2", rdata, 32'h0);
        chk("R2", outs(), 32'h0);

        // R3 line sweep: two-edge latency
        prev = 2'b00;
        for (int v = 0; v < 4; v++) begin
            line_raw = v[1:0];
            step();
            chk("R3", {30'd0, rdata[11:10]}, {30'd0, prev});
            step();
            chk("R3", {30'd0, rdata[11:10]}, {30'd0, v[1:0]});
            prev = v[1:0];
        end
        line_raw = 2'b00;
        step(); step();

        // R11 reset write while disconnected
        wr(8'h30, 32'h100);
        chk("R11", rdata, 32'h0);
        chk("R11", {31'd0, drv_reset}, 32'h0);

        // R1 other address: no read, no write
        wr(8'h34, 32'hFFFF_FFFF);
        addr = 8'h34;
        #1;
        chk("R1", rdata, 32'h0);
        addr = 8'h30;
        #1;
        chk("R1", rdata, 32'h0);
        // R1 reserved bits stay zero
        wr(8'h30, 32'hFFFF_FFFF);
        chk("R1", rdata, 32'h0001_0000);
        chk("R9", {31'd0, drv_force_hs}, 32'h1);
        wr(8'h30, 32'h0);
        chk("R9", {31'd0, drv_force_hs}, 32'h0);

        // R4 R5 attach
        connect = 1'b1;
        step();
        chk("R4", rdata, 32'h3);
        chk("R5", {31'd0, csc_irq}, 32'h1);
        step();
        chk("R5", rdata, 32'h3);
        wr(8'h30, 32'h2);
        chk("R5", rdata, 32'h1);
        chk("R5", {31'd0, csc_irq}, 32'h0);

        // R7 reset attempt while running
        run_stop = 1'b1;
        wr(8'h30, 32'h100);
        chk("R7", rdata, 32'h1);
        chk("R7", {31'd0, prot_err}, 32'h1);
        step();
        chk("R7", {31'd0, prot_err}, 32'h0);

        // R6 bus reset start/stop
        run_stop = 1'b0;
        wr(8'h30, 32'h100);
        chk("R6", rdata, 32'h101);
        chk("R6", {31'd0, drv_reset}, 32'h1);
        wr(8'h30, 32'h100);
        chk("R6", rdata, 32'h101);
        wr(8'h30, 32'h0);
        chk("R6", rdata, 32'h5);
        chk("R6", {31'd0, port_enabled}, 32'h1);

        // R10 SOF permission
        #1;
        chk("R10", {31'd0, sof_enable}, 32'h0);
        run_stop = 1'b1;
        #1;
        chk("R10", {31'd0, sof_enable}, 32'h1);

        // R8 suspend/resume
        wr(8'h30, 32'h80);
        chk("R8", rdata, 32'h85);
        chk("R8", {31'd0, drv_suspend}, 32'h1);
        chk("R10", {31'd0, sof_enable}, 32'h0);
        wr(8'h30, 32'h0);
        chk("R8", rdata, 32'h5);

        // R7 in EN
        wr(8'h30, 32'h100);
        chk("R7", rdata, 32'h5);
        chk("R7", {31'd0, prot_err}, 32'h1);
        run_stop = 1'b0;

        // R8 suspend write during reset ignored
        wr(8'h30, 32'h100);
        wr(8'h30, 32'h180);
        chk("R8", rdata, 32'h101);
        wr(8'h30, 32'h0);
        chk("R6", rdata, 32'h5);

        // R6 reset from SUSP, then R4 detach from SUSP
        wr(8'h30, 32'h80);
        wr(8'h30, 32'h100);
        chk("R6", rdata, 32'h101);
        wr(8'h30, 32'h0);
        wr(8'h30, 32'h80);
        chk("R8", rdata, 32'h85);
        connect = 1'b0;
        step();
        chk("R4", rdata, 32'h2);
        chk("R4", outs(), 32'h2);

        // R9 force enable
        wr(8'h30, 32'h1_0002);
        chk("R9", rdata, 32'h1_0000);
        connect = 1'b1;
        step();
        chk("R9", rdata, 32'h1_0003);
        step();
        chk("R9", rdata, 32'h1_0007);

        // R8 suspend write in CONN ignored
        wr(8'h30, 32'h2);
        connect = 1'b0;
        step();
        connect = 1'b1;
        step();
        chk("R4", rdata, 32'h3);
        wr(8'h30, 32'h82);
        chk("R8", rdata, 32'h1);
        step();
        chk("R8", rdata, 32'h1);

        // R2 host controller reset pulse
        wr(8'h30, 32'h1_0000);
        hc_reset = 1'b1;
        step();
        hc_reset = 1'b0;
        chk("R2", rdata, 32'h0);
        chk("R2", outs(), 32'h0);
        step();
        chk("R5", rdata, 32'h3);

        // R2 power-on reset
        wr(8'h30, 32'h1_0000);
        por_n = 1'b0;
        #1;
        chk("R2", rdata, 32'h0);
        connect = 1'b0;
        step();
        por_n = 1'b1;
        step();
        chk("R2", rdata, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule